// File: doc/BRIEF.md
# MAC Forwarding-Table Slot Allocator

This block carries out insert and remove commands for MAC-address entries in an external forwarding table. A command can be one of four kinds: add a unicast address, remove a unicast address, add a multicast address, or remove ports from a multicast address. When the block accepts a command, it reads every table row once, in index order. During that read it records three candidate rows: the first row that holds the same address, the first empty row, and the first row whose entry may be evicted. After the last row it picks the highest-priority candidate. It then builds the new entry and issues a single write request to the table storage. In the same cycle it reports a status and the chosen index.

The table storage sits outside the block and answers a read one cycle after the request. The block does not contain the storage array, does not age entries, and takes no part in per-frame lookups.

Top module: `mac_slot_alloc`

## Requirements
- R1: A unicast add writes an entry with these fields: the 48-bit address in bits 47:0, with address byte 0 in bits 47:40 and byte 5 in bits 7:0; entry kind 1 in bits 61:60; sub-type 0 (permanent) in bits 63:62; the secure flag in bit 64; the blocked flag in bit 65; the port number in bits 67:66. Every other bit is zero.
- R2: A row counts as an address match only if its kind (bits 61:60) is 1 or 3 and all 48 address bits are equal. When several rows match, the lowest index is used.
- R3: An add goes to the matching row if one exists. Otherwise it goes to the lowest-index empty row (kind 0). Otherwise it goes to the lowest-index evictable row. If none of these exists, the status is 1 (no space) and no write is made. Status 0 means success.
- R4: A row is evictable when all three hold: its kind is 1 or 3, bit 40 is clear, and its sub-type (bits 63:62) is 1 or 3. Sub-types 0 and 2 are never evicted.
- R5: A multicast add writes kind 1, the address, the super flag in bit 65, and the multicast state in bits 63:62. Its port mask in bits 68:66 is the OR of the requested mask and the mask of the matching row, if there is one. All other fields of a matching row are kept.
- R6: A unicast remove on a matching row writes an all-zero entry, which has kind 0 (empty). If there is no match, it reports status 2 (not found) and makes no write.
- R7: A multicast remove with a non-zero mask replaces the port mask of the matching row and keeps its other fields. With a zero mask, it sets the row's kind to 0 and keeps its other fields. If there is no match, it reports status 2 and makes no write.
- R8: cmd_ready is high only while the block is idle. Each accepted command produces exactly one single-cycle rsp_valid pulse. A write request is issued only in that same cycle, and only on success.
- R9: Each command reads rows 0 to DEPTH-1 once each, in increasing order, one row per cycle.
- R10: After reset, cmd_ready is 1, and rsp_valid, tbl_rd_en and tbl_wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; a command is taken when both cmd_valid and cmd_ready are high |
| cmd_op | input | 2 | 0 add unicast, 1 remove unicast, 2 add multicast, 3 remove multicast |
| cmd_mac | input | 48 | MAC address; byte 0 in bits 47:40 |
| cmd_port | input | $clog2(NUM_PORTS) | Port number for a unicast add |
| cmd_mask | input | NUM_PORTS | Port mask for multicast commands |
| cmd_secure | input | 1 | Secure flag for a unicast add |
| cmd_blocked | input | 1 | Blocked flag for a unicast add |
| cmd_super | input | 1 | Super flag for a multicast add |
| cmd_mstate | input | 2 | Multicast forwarding state |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_idx | output | $clog2(DEPTH) | Table row being read |
| tbl_rd_data | input | 66+NUM_PORTS | Row contents, one cycle after the request |
| tbl_wr_en | output | 1 | Table write request |
| tbl_wr_idx | output | $clog2(DEPTH) | Row being written |
| tbl_wr_data | output | 66+NUM_PORTS | New row contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_status | output | 2 | 0 ok, 1 no space, 2 not found |
| rsp_idx | output | $clog2(DEPTH) | Chosen row (0 on failure) |

## Verification
The assertions check, on every cycle, the properties that involve no table contents:
- Reads run in strictly increasing index order.
- cmd_ready falls once a command is accepted.
- A write occurs only together with a success response.
- The first recorded match is held for the rest of the scan.

Only the bench scenarios can show the choices that depend on what the table holds. These are the priority between a match, an empty row and an evictable row; which rows count as evictable; the exact bit layout of each written entry; and the OR-merge and replace-or-free effects of the multicast commands.

// File: rtl/mac_alloc_pkg.sv
package mac_alloc_pkg;
  typedef enum logic [1:0] {
    OP_ADD_UC = 2'd0,
    OP_DEL_UC = 2'd1,
    OP_ADD_MC = 2'd2,
    OP_DEL_MC = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NOSPACE  = 2'd1,
    ST_NOTFOUND = 2'd2
  } sts_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_SCAN = 2'd1,
    FSM_DONE = 2'd2
  } fsm_e;

  // field positions inside a table row
  localparam int MAC_W    = 48;
  localparam int GRP_BIT  = 40;
  localparam int KIND_LO  = 60;
  localparam int SUB_LO   = 62;
  localparam int FLAG_A   = 64;
  localparam int FLAG_B   = 65;
  localparam int OWNER_LO = 66;

  localparam logic [1:0] KIND_EMPTY = 2'd0;
  localparam logic [1:0] KIND_ADDR  = 2'd1;
  localparam logic [1:0] KIND_VADDR = 2'd3;
endpackage

// File: rtl/slot_scan.sv
module slot_scan
  import mac_alloc_pkg::*;
#(
  parameter int ENTRY_W = 69,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               vld,
  input  logic [IDX_W-1:0]   idx,
  input  logic [ENTRY_W-1:0] ent,
  input  logic [MAC_W-1:0]   key_mac,
  output logic               found_match,
  output logic [IDX_W-1:0]   match_idx,
  output logic [ENTRY_W-1:0] match_ent,
  output logic               found_free,
  output logic [IDX_W-1:0]   free_idx,
  output logic               found_age,
  output logic [IDX_W-1:0]   age_idx
);
  logic [1:0]         kind;
  logic               is_addr, hit, empty, evictable;
  logic               fm_d, ff_d, fa_d;
  logic [IDX_W-1:0]   mi_d, fi_d, ai_d;
  logic [ENTRY_W-1:0] me_d;

  assign kind      = ent[KIND_LO +: 2];
  assign is_addr   = (kind == KIND_ADDR) || (kind == KIND_VADDR);
  assign hit       = is_addr && (ent[MAC_W-1:0] == key_mac);
  assign empty     = (kind == KIND_EMPTY);
  assign evictable = is_addr && !ent[GRP_BIT] && ent[SUB_LO];

  always_comb begin
    fm_d = found_match; mi_d = match_idx; me_d = match_ent;
    ff_d = found_free;  fi_d = free_idx;
    fa_d = found_age;   ai_d = age_idx;
    if (clr) begin
      fm_d = 1'b0; mi_d = '0; me_d = '0;
      ff_d = 1'b0; fi_d = '0;
      fa_d = 1'b0; ai_d = '0;
    end else if (vld) begin
      if (!found_match && hit) begin
        fm_d = 1'b1; mi_d = idx; me_d = ent;
      end
      if (!found_free && empty) begin
        ff_d = 1'b1; fi_d = idx;
      end
      if (!found_age && evictable) begin
        fa_d = 1'b1; ai_d = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_match <= 1'b0; match_idx <= '0; match_ent <= '0;
      found_free  <= 1'b0; free_idx  <= '0;
      found_age   <= 1'b0; age_idx   <= '0;
    end else begin
      found_match <= fm_d; match_idx <= mi_d; match_ent <= me_d;
      found_free  <= ff_d; free_idx  <= fi_d;
      found_age   <= fa_d; age_idx   <= ai_d;
    end
  end

  // R2: the lowest matching row, once recorded, is kept for the rest of the scan
  a_r2_first_match_held: assert property (@(posedge clk) disable iff (!rst_n)
    (found_match && !clr) |=> (found_match && $stable(match_idx)));

  // R3: the lowest empty row, once recorded, is kept
  a_r3_first_free_held: assert property (@(posedge clk) disable iff (!rst_n)
    (found_free && !clr) |=> (found_free && $stable(free_idx)));
endmodule

// File: rtl/entry_compose.sv
module entry_compose
  import mac_alloc_pkg::*;
#(
  parameter int ENTRY_W = 69,
  parameter int IDX_W   = 4,
  parameter int MASK_W  = 3,
  parameter int PNUM_W  = 2
) (
  input  op_e                op,
  input  logic [MAC_W-1:0]   mac,
  input  logic [PNUM_W-1:0]  port,
  input  logic [MASK_W-1:0]  mask,
  input  logic               secure,
  input  logic               blocked,
  input  logic               sup,
  input  logic [1:0]         mstate,
  input  logic               found_match,
  input  logic [IDX_W-1:0]   match_idx,
  input  logic [ENTRY_W-1:0] match_ent,
  input  logic               found_free,
  input  logic [IDX_W-1:0]   free_idx,
  input  logic               found_age,
  input  logic [IDX_W-1:0]   age_idx,
  output logic               wr_req,
  output logic [IDX_W-1:0]   pick_idx,
  output logic [ENTRY_W-1:0] wr_data,
  output sts_e               status
);
  logic               slot_ok;
  logic [IDX_W-1:0]   slot_idx;
  logic [ENTRY_W-1:0] base;

  // add priority: existing match, first empty, first evictable
  always_comb begin
    slot_ok  = 1'b1;
    slot_idx = '0;
    if (found_match)     slot_idx = match_idx;
    else if (found_free) slot_idx = free_idx;
    else if (found_age)  slot_idx = age_idx;
    else                 slot_ok  = 1'b0;
  end

  always_comb begin
    wr_req   = 1'b0;
    pick_idx = '0;
    wr_data  = '0;
    status   = ST_OK;
    base     = match_ent;
    unique case (op)
      OP_ADD_UC: begin
        wr_data[MAC_W-1:0]         = mac;
        wr_data[KIND_LO +: 2]      = KIND_ADDR;
        wr_data[FLAG_A]            = secure;
        wr_data[FLAG_B]            = blocked;
        wr_data[OWNER_LO +: PNUM_W] = port;
        if (slot_ok) begin
          wr_req = 1'b1; pick_idx = slot_idx;
        end else begin
          status = ST_NOSPACE;
        end
      end
      OP_ADD_MC: begin
        if (!found_match) base = '0;
        wr_data                    = base;
        wr_data[MAC_W-1:0]         = mac;
        wr_data[KIND_LO +: 2]      = KIND_ADDR;
        wr_data[SUB_LO +: 2]       = mstate;
        wr_data[FLAG_B]            = sup;
        wr_data[OWNER_LO +: MASK_W] = base[OWNER_LO +: MASK_W] | mask;
        if (slot_ok) begin
          wr_req = 1'b1; pick_idx = slot_idx;
        end else begin
          status = ST_NOSPACE;
        end
      end
      OP_DEL_UC: begin
        if (found_match) begin
          wr_req = 1'b1; pick_idx = match_idx;
        end else begin
          status = ST_NOTFOUND;
        end
      end
      OP_DEL_MC: begin
        wr_data = match_ent;
        if (mask != '0) wr_data[OWNER_LO +: MASK_W] = mask;
        else            wr_data[KIND_LO +: 2]       = KIND_EMPTY;
        if (found_match) begin
          wr_req = 1'b1; pick_idx = match_idx;
        end else begin
          status = ST_NOTFOUND;
        end
      end
      default: status = ST_OK;
    endcase
  end
endmodule

// File: rtl/mac_slot_alloc.sv
module mac_slot_alloc
  import mac_alloc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_PORTS = 3,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int MASK_W   = NUM_PORTS,
  localparam int PNUM_W   = $clog2(NUM_PORTS),
  localparam int ENTRY_W  = OWNER_LO + MASK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [47:0]        cmd_mac,
  input  logic [PNUM_W-1:0]  cmd_port,
  input  logic [MASK_W-1:0]  cmd_mask,
  input  logic               cmd_secure,
  input  logic               cmd_blocked,
  input  logic               cmd_super,
  input  logic [1:0]         cmd_mstate,
  output logic               tbl_rd_en,
  output logic [IDX_W-1:0]   tbl_rd_idx,
  input  logic [ENTRY_W-1:0] tbl_rd_data,
  output logic               tbl_wr_en,
  output logic [IDX_W-1:0]   tbl_wr_idx,
  output logic [ENTRY_W-1:0] tbl_wr_data,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [IDX_W-1:0]   rsp_idx
);
  localparam logic [IDX_W:0]   PTR_END  = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0; rst_sync_n <= 1'b0;
    end else begin
      rst_meta <= 1'b1; rst_sync_n <= rst_meta;
    end
  end

  fsm_e            state_q, state_d;
  logic [IDX_W:0]  ptr_q, ptr_d;
  logic            rvld_q;
  logic [IDX_W-1:0] ridx_q;
  logic            accept, scan_last;

  op_e               op_q;
  logic [47:0]       mac_q;
  logic [PNUM_W-1:0] port_q;
  logic [MASK_W-1:0] mask_q;
  logic              sec_q, blk_q, sup_q;
  logic [1:0]        mst_q;

  assign cmd_ready  = (state_q == FSM_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign tbl_rd_en  = (state_q == FSM_SCAN) && (ptr_q < PTR_END);
  assign tbl_rd_idx = ptr_q[IDX_W-1:0];
  assign scan_last  = rvld_q && (ridx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      FSM_IDLE: if (accept) begin
        state_d = FSM_SCAN; ptr_d = '0;
      end
      FSM_SCAN: begin
        if (tbl_rd_en) ptr_d = ptr_q + 1'b1;
        if (scan_last) state_d = FSM_DONE;
      end
      FSM_DONE: state_d = FSM_IDLE;
      default:  state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= FSM_IDLE;
      ptr_q   <= '0;
      rvld_q  <= 1'b0;
      ridx_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      rvld_q  <= tbl_rd_en;
      ridx_q  <= tbl_rd_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q <= OP_ADD_UC; mac_q <= '0; port_q <= '0; mask_q <= '0;
      sec_q <= 1'b0; blk_q <= 1'b0; sup_q <= 1'b0; mst_q <= '0;
    end else if (accept) begin
      op_q <= op_e'(cmd_op); mac_q <= cmd_mac; port_q <= cmd_port; mask_q <= cmd_mask;
      sec_q <= cmd_secure; blk_q <= cmd_blocked; sup_q <= cmd_super; mst_q <= cmd_mstate;
    end
  end

  logic               fm, ff, fa;
  logic [IDX_W-1:0]   mi, fi, ai;
  logic [ENTRY_W-1:0] me;

  slot_scan #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .clr(accept),
    .vld(rvld_q), .idx(ridx_q), .ent(tbl_rd_data), .key_mac(mac_q),
    .found_match(fm), .match_idx(mi), .match_ent(me),
    .found_free(ff), .free_idx(fi), .found_age(fa), .age_idx(ai)
  );

  logic               wr_req;
  logic [IDX_W-1:0]   pick;
  logic [ENTRY_W-1:0] new_ent;
  sts_e               sts;

  entry_compose #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .MASK_W(MASK_W), .PNUM_W(PNUM_W)) u_comp (
    .op(op_q), .mac(mac_q), .port(port_q), .mask(mask_q),
    .secure(sec_q), .blocked(blk_q), .sup(sup_q), .mstate(mst_q),
    .found_match(fm), .match_idx(mi), .match_ent(me),
    .found_free(ff), .free_idx(fi), .found_age(fa), .age_idx(ai),
    .wr_req(wr_req), .pick_idx(pick), .wr_data(new_ent), .status(sts)
  );

  assign rsp_valid   = (state_q == FSM_DONE);
  assign rsp_status  = sts;
  assign rsp_idx     = pick;
  assign tbl_wr_en   = rsp_valid && wr_req;
  assign tbl_wr_idx  = pick;
  assign tbl_wr_data = new_ent;

  // R9: consecutive reads step up by one row
  a_r9_read_order: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tbl_rd_en && $past(tbl_rd_en)) |-> (tbl_rd_idx == $past(tbl_rd_idx) + 1'b1));

  // R8: a taken command drops ready on the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8: a write only comes with a response
  a_r8_write_with_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tbl_wr_en |-> rsp_valid);

  // R8: the response lasts one cycle
  a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> !rsp_valid);

  // R3 / R6 / R7: failures never write
  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && (rsp_status != 2'd0)) |-> !tbl_wr_en);

  // R9: no read while a response is pending
  a_r9_no_read_in_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> !tbl_rd_en);
endmodule

// File: tb/mac_slot_alloc_tb.sv
module mac_slot_alloc_tb;
  localparam int DEPTH = 16;
  localparam int EW    = 69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [47:0]   cmd_mac = '0;
  logic [1:0]    cmd_port = '0;
  logic [2:0]    cmd_mask = '0;
  logic          cmd_secure = 1'b0, cmd_blocked = 1'b0, cmd_super = 1'b0;
  logic [1:0]    cmd_mstate = '0;
  logic          tbl_rd_en, tbl_wr_en, rsp_valid;
  logic [3:0]    tbl_rd_idx, tbl_wr_idx, rsp_idx;
  logic [EW-1:0] tbl_rd_data, tbl_wr_data;
  logic [1:0]    rsp_status;

  mac_slot_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mac(cmd_mac), .cmd_port(cmd_port), .cmd_mask(cmd_mask),
    .cmd_secure(cmd_secure), .cmd_blocked(cmd_blocked), .cmd_super(cmd_super),
    .cmd_mstate(cmd_mstate), .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
    .tbl_rd_data(tbl_rd_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_data(tbl_wr_data), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_idx(rsp_idx)
  );

  // table storage model
  logic [EW-1:0] mem [DEPTH];
  int wr_cnt = 0;
  int rd_next = 0;
  bit rd_bad = 1'b0;
  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_rd_data <= mem[tbl_rd_idx];
      if (int'(tbl_rd_idx) != rd_next) rd_bad = 1'b1;
      rd_next = rd_next + 1;
    end
    if (tbl_wr_en) begin
      mem[tbl_wr_idx] <= tbl_wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [1:0] got_sts;
  logic [3:0] got_idx;

  task automatic chk(input bit ok, input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] uc_ent(input logic [47:0] mac, input logic [1:0] kind,
                                           input logic [1:0] sub, input logic [1:0] port);
    logic [EW-1:0] e = '0;
    e[47:0] = mac; e[61:60] = kind; e[63:62] = sub; e[67:66] = port;
    return e;
  endfunction

  function automatic logic [47:0] mac_of(input int i);
    return 48'h0200_0000_1000 + 48'(i);
  endfunction

  task automatic fill_perm();
    for (int i = 0; i < DEPTH; i++) mem[i] = uc_ent(mac_of(i), 2'd1, 2'd0, 2'd0);
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [47:0] mac, input logic [1:0] port,
                         input logic [2:0] mask, input bit sec, input bit blk, input bit sup,
                         input logic [1:0] mst);
    int n;
    bit busy_ok;
    @(negedge clk);
    cmd_op = op; cmd_mac = mac; cmd_port = port; cmd_mask = mask;
    cmd_secure = sec; cmd_blocked = blk; cmd_super = sup; cmd_mstate = mst;
    rd_next = 0; rd_bad = 1'b0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0; busy_ok = 1'b1;
    while (!rsp_valid && n < 200) begin
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n < 200, "R8 response arrives", EW'(n), EW'(200));
    chk(busy_ok && !cmd_ready, "R8 ready low while busy", EW'(cmd_ready), '0);
    got_sts = rsp_status; got_idx = rsp_idx;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R8 single pulse then idle", EW'({rsp_valid, cmd_ready}), EW'(2'b01));
    chk(rd_next == DEPTH && !rd_bad, "R9 read order", EW'(rd_next), EW'(DEPTH));
  endtask

  task automatic t_reset();
    chk(cmd_ready && !rsp_valid && !tbl_wr_en && !tbl_rd_en, "R10 reset state",
        EW'({cmd_ready, rsp_valid, tbl_wr_en, tbl_rd_en}), EW'(4'b1000));
  endtask

  task automatic t_uc_layout();
    logic [EW-1:0] exp;
    int w0;
    clear_tbl();
    w0 = wr_cnt;
    run_cmd(2'd0, 48'h0A1B_2C3D_4E5F, 2'd2, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0);
    exp = '0; exp[47:0] = 48'h0A1B_2C3D_4E5F; exp[61:60] = 2'd1; exp[64] = 1'b1; exp[67:66] = 2'd2;
    chk(got_sts == 2'd0 && got_idx == 4'd0, "R3 empty table uses row 0", EW'({got_sts, got_idx}), '0);
    chk(mem[0] == exp, "R1 unicast entry layout", mem[0], exp);
    chk(mem[0][47:40] == 8'h0A, "R1 byte 0 in top byte", EW'(mem[0][47:40]), EW'(8'h0A));
    chk(wr_cnt - w0 == 1, "R8 one write", EW'(wr_cnt - w0), EW'(1));
  endtask

  task automatic t_match();
    logic [47:0] m = 48'h00AA_BBCC_DDEE;
    clear_tbl();
    mem[1] = uc_ent(m, 2'd2, 2'd0, 2'd0);          // kind 2 ignored
    mem[2] = uc_ent(m ^ 48'd1, 2'd1, 2'd0, 2'd0);  // differs in bit 0
    mem[3] = uc_ent(m, 2'd3, 2'd0, 2'd1);          // first real match
    mem[7] = uc_ent(m, 2'd1, 2'd0, 2'd1);
    run_cmd(2'd0, m, 2'd1, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0);
    chk(got_sts == 2'd0 && got_idx == 4'd3, "R2 lowest match beats empty row 0", EW'(got_idx), EW'(3));
    chk(mem[3][65] == 1'b1 && mem[3][61:60] == 2'd1, "R1 blocked flag and kind", mem[3], '0);
    chk(mem[0] == '0 && mem[7] == uc_ent(m, 2'd1, 2'd0, 2'd1), "R2 other rows untouched", mem[7], '0);
  endtask

  task automatic t_evict();
    int w0;
    fill_perm();
    mem[3]  = uc_ent(mac_of(3), 2'd1, 2'd2, 2'd0);                     // OUI kept
    mem[5]  = uc_ent(mac_of(5) | 48'h0100_0000_0000, 2'd1, 2'd3, 2'd0); // group bit
    mem[7]  = uc_ent(mac_of(7), 2'd2, 2'd3, 2'd0);                     // wrong kind
    mem[9]  = uc_ent(mac_of(9), 2'd1, 2'd1, 2'd0);                     // evictable
    mem[12] = uc_ent(mac_of(12), 2'd3, 2'd3, 2'd0);
    w0 = wr_cnt;
    run_cmd(2'd0, 48'h0A00_0000_0001, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(got_sts == 2'd0 && got_idx == 4'd9, "R4 first evictable row", EW'(got_idx), EW'(9));
    chk(wr_cnt - w0 == 1 && mem[9][47:0] == 48'h0A00_0000_0001, "R4 evicted row rewritten", mem[9], '0);
  endtask

  task automatic t_nospace();
    int w0;
    fill_perm();
    mem[4] = uc_ent(mac_of(4), 2'd3, 2'd2, 2'd0);
    w0 = wr_cnt;
    run_cmd(2'd0, 48'h0A00_0000_0002, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(got_sts == 2'd1, "R3 no space status", EW'(got_sts), EW'(1));
    chk(wr_cnt == w0, "R3 no write when full", EW'(wr_cnt - w0), '0);
  endtask

  task automatic t_free();
    fill_perm();
    mem[2]  = uc_ent(mac_of(2), 2'd1, 2'd3, 2'd0);
    mem[6]  = '0;
    mem[11] = '0;
    run_cmd(2'd2, 48'h0100_5E00_0007, 2'd0, 3'b011, 1'b0, 1'b0, 1'b1, 2'd1);
    chk(got_sts == 2'd0 && got_idx == 4'd6, "R3 empty row beats evictable", EW'(got_idx), EW'(6));
  endtask

  task automatic t_del_uc();
    int w0;
    clear_tbl();
    mem[4] = uc_ent(48'h0033_4455_6677, 2'd1, 2'd0, 2'd2);
    run_cmd(2'd1, 48'h0033_4455_6677, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(got_sts == 2'd0 && got_idx == 4'd4 && mem[4] == '0, "R6 remove frees row", mem[4], '0);
    w0 = wr_cnt;
    run_cmd(2'd1, 48'h0033_4455_6678, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(got_sts == 2'd2 && wr_cnt == w0, "R6 miss reports not found", EW'(got_sts), EW'(2));
  endtask

  task automatic t_mc_add();
    logic [EW-1:0] exp, old;
    clear_tbl();
    mem[0] = uc_ent(mac_of(0), 2'd1, 2'd0, 2'd0);
    run_cmd(2'd2, 48'h0100_5E00_0001, 2'd0, 3'b010, 1'b0, 1'b0, 1'b1, 2'd3);
    exp = '0; exp[47:0] = 48'h0100_5E00_0001; exp[61:60] = 2'd1; exp[63:62] = 2'd3;
    exp[65] = 1'b1; exp[68:66] = 3'b010;
    chk(got_idx == 4'd1 && mem[1] == exp, "R5 new multicast entry", mem[1], exp);
    old = '0; old[47:0] = 48'h0100_5E00_00AA; old[61:60] = 2'd3; old[59:48] = 12'h123;
    old[63:62] = 2'd1; old[68:66] = 3'b001;
    mem[5] = old;
    run_cmd(2'd2, 48'h0100_5E00_00AA, 2'd0, 3'b100, 1'b0, 1'b0, 1'b0, 2'd2);
    exp = old; exp[61:60] = 2'd1; exp[63:62] = 2'd2; exp[65] = 1'b0; exp[68:66] = 3'b101;
    chk(got_idx == 4'd5 && mem[5] == exp, "R5 mask merged by OR", mem[5], exp);
  endtask

  task automatic t_mc_del();
    logic [EW-1:0] e, exp;
    int w0;
    clear_tbl();
    e = '0; e[47:0] = 48'h0100_5E00_0042; e[61:60] = 2'd1; e[63:62] = 2'd3; e[65] = 1'b1;
    e[68:66] = 3'b111;
    mem[8] = e;
    run_cmd(2'd3, 48'h0100_5E00_0042, 2'd0, 3'b010, 1'b0, 1'b0, 1'b0, 2'd0);
    exp = e; exp[68:66] = 3'b010;
    chk(got_idx == 4'd8 && mem[8] == exp, "R7 mask replaced", mem[8], exp);
    run_cmd(2'd3, 48'h0100_5E00_0042, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0);
    exp[61:60] = 2'd0;
    chk(mem[8] == exp, "R7 zero mask frees row", mem[8], exp);
    w0 = wr_cnt;
    run_cmd(2'd3, 48'h0100_5E00_0042, 2'd0, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(got_sts == 2'd2 && wr_cnt == w0, "R7 miss reports not found", EW'(got_sts), EW'(2));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    tbl_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_uc_layout();
    t_match();
    t_evict();
    t_nospace();
    t_free();
    t_del_uc();
    t_mc_add();
    t_mc_del();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule